// File: doc/BRIEF.md
# I2C Master Write Engine

This block is the transmit side of an I2C bus master. Software steers it through a handful of plain control pins:
- a global enable;
- a transmit-interrupt enable;
- one-cycle requests that set a START bit and a STOP bit.

Bytes are handed over one at a time through a single-entry holding register. The engine generates the START condition and shifts each byte out most significant bit first. It releases SDA for the acknowledge slot and samples the slave's answer there. It waits whenever a slave stretches SCL, and it ends the transfer with a STOP condition. Both bus lines are open-drain. An output-enable high pulls the line low, and the line level is read back on a separate input.

The byte path is a valid/ready stream.
- `wr_ready` is high exactly while the holding register is empty.
- A byte is taken on any clock edge where `wr_valid` and `wr_ready` are both high.
- A producer that sees `wr_ready` low keeps `wr_data` and `wr_valid` steady until it rises.
- The register empties, and `wr_ready` rises again, in the cycle after the engine copies the byte into its shifter at the start of a byte on the bus.

Software sends a 7-bit address byte with R/W = 0 as the first byte. For a 10-bit slave it sends two bytes first. The first is `11110`, then address bits 9 and 8, then 0. The second holds address bits 7..0. Data bytes follow in the same way in both cases.

Top module: `i2cm_tx`

## Requirements
- R1: After reset both open-drain enables are low, `busy` is low, the holding register is empty (`tx_empty` = 1, `wr_ready` = 1), and `start_pend`, `stop_pend`, `nack_flag` and `irq` are all 0.
- R2: `wr_ready` equals `tx_empty`. An accepted write clears `tx_empty`. The copy of the held byte into the shifter, at the start of every byte on the bus, sets `tx_empty` again.
- R3: `irq` is high exactly when `cfg_en`, `cfg_txie` and `tx_empty` are all 1.
- R4: A START happens only while `cfg_en` = 1, the START bit is pending and a byte is held. A START is SDA falling while SCL is high. The START bit clears by itself once the START has been driven.
- R5: Each byte is sent MSB first on eight SCL pulses. In those pulses SDA changes only while SCL is low. On the ninth pulse the engine releases SDA.
- R6: If SDA is low in the ninth pulse (ACK), the transfer goes on. If it is high (NACK), the engine sends STOP, discards any held byte and sets `nack_flag`. The flag stays set until the next `start_req`.
- R7: After an acknowledged byte, STOP is sent if the STOP bit is pending or no byte is held. A held byte stays in the register. STOP is SDA rising while SCL is high, and the STOP bit clears by itself once it is driven.
- R8: While SCL has been released but a slave still holds the line low, the engine makes no progress. The released high phase then lasts its full length after the line rises.
- R9: In a 10-bit write, the bytes `11110 A9 A8 0` and `A7..A0` go out unchanged and are followed by the data bytes.
- R10: With no stretching, successive SCL rising edges in a transfer are exactly 4·QDIV clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Global enable |
| cfg_txie | input | 1 | Transmit-interrupt enable |
| start_req | input | 1 | One-cycle pulse: set the START bit, clear `nack_flag` |
| stop_req | input | 1 | One-cycle pulse: set the STOP bit |
| wr_valid | input | 1 | Byte offered to the holding register |
| wr_ready | output | 1 | Holding register can accept a byte |
| wr_data | input | 8 | Byte offered |
| scl_in | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low |
| start_pend | output | 1 | START bit |
| stop_pend | output | 1 | STOP bit |
| tx_empty | output | 1 | Holding register empty |
| irq | output | 1 | Transmit interrupt |
| nack_flag | output | 1 | Sticky NACK status |
| busy | output | 1 | Transfer in progress |

## Verification
A wrong phase or bit count shows up within one bit period (4·QDIV cycles). It appears either as a byte shifted by one position at the modelled slave, or as a false START or STOP seen while SCL is high. A wrong empty flag shows up within one cycle on `wr_ready` and `irq`. Within a byte it also shows up as a dropped, repeated or left-over byte at the next acknowledge decision. A bad stretch or acknowledge path shows up within the stretched bit or the ninth pulse, as a short high phase or a missing STOP.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BIT   = 2'd2,
    ST_STOP  = 2'd3
  } eng_st_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST) && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R10: the quarter counter never leaves its range
  a_r10_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/i2cm_txbuf.sv
module i2cm_txbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         take,
  output logic [W-1:0] held,
  output logic         empty
);
  assign wr_ready = empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty <= 1'b1;
      held  <= '0;
    end else if (take) begin
      empty <= 1'b1;
    end else if (wr_valid && wr_ready) begin
      empty <= 1'b0;
      held  <= wr_data;
    end
  end

  // R2: a copy into the shifter empties the register
  a_r2_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> empty);
  // R2: an accepted byte fills the register with that byte
  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !take) |=> (!empty && held == $past(wr_data)));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         qtick,
  input  logic         go,
  input  logic         stop_pend,
  input  logic         buf_empty,
  input  logic [W-1:0] buf_q,
  input  logic         scl_in,
  input  logic         sda_in,
  output logic         scl_oe,
  output logic         sda_oe,
  output logic         take,
  output logic         start_done,
  output logic         stop_done,
  output logic         nack_set,
  output logic         busy
);
  localparam int BCW = $clog2(W + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(W);

  eng_st_t        st;
  logic [1:0]     ph;
  logic [BCW-1:0] bitcnt;
  logic [W-1:0]   shreg;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ph         <= 2'd0;
      bitcnt     <= '0;
      shreg      <= '0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      take       <= 1'b0;
      start_done <= 1'b0;
      stop_done  <= 1'b0;
      nack_set   <= 1'b0;
    end else begin
      take       <= 1'b0;
      start_done <= 1'b0;
      stop_done  <= 1'b0;
      nack_set   <= 1'b0;
      if (qtick) begin
        case (st)
          ST_IDLE: begin
            if (go) begin
              st    <= ST_START;
              ph    <= 2'd0;
              shreg <= buf_q;
              take  <= 1'b1;
            end
          end
          ST_START: begin
            ph <= ph + 2'd1;
            if (ph == 2'd1) sda_oe <= 1'b1;
            if (ph == 2'd3) begin
              st         <= ST_BIT;
              scl_oe     <= 1'b1;
              bitcnt     <= '0;
              start_done <= 1'b1;
            end
          end
          ST_BIT: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= (bitcnt == ACK_SLOT) ? 1'b0 : !shreg[W-1];
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin
                scl_oe <= 1'b1;
                if (bitcnt != ACK_SLOT) begin
                  shreg  <= {shreg[W-2:0], 1'b0};
                  bitcnt <= bitcnt + 1'b1;
                end else if (sda_in) begin
                  nack_set <= 1'b1;
                  take     <= 1'b1;
                  st       <= ST_STOP;
                end else if (stop_pend || buf_empty) begin
                  st <= ST_STOP;
                end else begin
                  shreg  <= buf_q;
                  take   <= 1'b1;
                  bitcnt <= '0;
                end
              end
            endcase
          end
          default: begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin
                sda_oe    <= 1'b0;
                st        <= ST_IDLE;
                stop_done <= 1'b1;
              end
            endcase
          end
        endcase
      end
    end
  end

  // R5: data SDA holds still while SCL is released
  a_r5_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && $past(st) == ST_BIT && !scl_oe && $past(!scl_oe))
      |-> $stable(sda_oe));
  // R5: SDA released in the acknowledge pulse
  a_r5_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && bitcnt == ACK_SLOT && ph >= 2'd2) |-> !sda_oe);
  // R4: SCL stays released through the START condition
  a_r4_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START) |-> !scl_oe);
  // R8: no progress while a slave holds SCL low
  a_r8_stretch_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_oe && !scl_in) |=> ($stable(ph) && $stable(st)));
endmodule

// File: rtl/i2cm_tx.sv
module i2cm_tx
  import i2cm_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_txie,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              scl_in,
  output logic              scl_oe,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              start_pend,
  output logic              stop_pend,
  output logic              tx_empty,
  output logic              irq,
  output logic              nack_flag,
  output logic              busy
);
  logic              qtick;
  logic              stall;
  logic              take;
  logic              start_done;
  logic              stop_done;
  logic              nack_set;
  logic [BYTE_W-1:0] held;
  logic              go;

  assign stall = !scl_oe && !scl_in;
  assign go    = cfg_en && start_pend && !tx_empty;
  assign irq   = cfg_en && cfg_txie && tx_empty;

  i2cm_qtick #(.QDIV(QDIV)) u_qtick (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (stall),
    .tick (qtick)
  );

  i2cm_txbuf #(.W(BYTE_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .wr_ready(wr_ready),
    .take    (take),
    .held    (held),
    .empty   (tx_empty)
  );

  i2cm_engine #(.W(BYTE_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .qtick     (qtick),
    .go        (go),
    .stop_pend (stop_pend),
    .buf_empty (tx_empty),
    .buf_q     (held),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .take      (take),
    .start_done(start_done),
    .stop_done (stop_done),
    .nack_set  (nack_set),
    .busy      (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
      nack_flag  <= 1'b0;
    end else begin
      if (start_req)       start_pend <= 1'b1;
      else if (start_done) start_pend <= 1'b0;
      if (stop_req)        stop_pend  <= 1'b1;
      else if (stop_done)  stop_pend  <= 1'b0;
      if (nack_set)        nack_flag  <= 1'b1;
      else if (start_req)  nack_flag  <= 1'b0;
    end
  end

  // R4: START bit self-clears once driven
  a_r4_start_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_done && !start_req) |=> !start_pend);
  // R7: STOP bit self-clears once driven
  a_r7_stop_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && !stop_req) |=> !stop_pend);
  // R6: a NACK leaves the sticky flag set
  a_r6_nack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nack_set |=> nack_flag);
endmodule

// File: tb/test_i2cm_tx.sv
module test_i2cm_tx;
  localparam int CLK_PERIOD = 10;
  localparam int QDIV       = 4;
  localparam int BITP       = 4 * QDIV;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0, cfg_txie = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, scl_oe, sda_oe, start_pend, stop_pend, tx_empty, irq, nack_flag, busy;
  logic       s_scl_low = 1'b0, s_sda_low = 1'b0;
  wire        scl_line = !(scl_oe || s_scl_low);
  wire        sda_line = !(sda_oe || s_sda_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_tx #(.QDIV(QDIV)) i_i2cm_tx (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_txie(cfg_txie),
    .start_req(start_req), .stop_req(stop_req), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .scl_in(scl_line), .scl_oe(scl_oe),
    .sda_in(sda_line), .sda_oe(sda_oe), .start_pend(start_pend),
    .stop_pend(stop_pend), .tx_empty(tx_empty), .irq(irq),
    .nack_flag(nack_flag), .busy(busy));

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // slave model state
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];
  logic [7:0] sh = 8'h00;
  int  bitpos = 0, byte_idx = 0, nack_at = -1;
  int  n_start = 0, n_stop = 0;
  int  stretch_len = 0, str_cnt = 0;
  int  last_rise = -1, max_per = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (str_cnt > 0) begin
      str_cnt--;
      if (str_cnt == 0) s_scl_low = 1'b0;
    end
    if (p_scl && scl_line && p_sda && !sda_line) begin
      n_start++; bitpos = 0; byte_idx = 0; last_rise = -1; max_per = 0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      n_stop++;
    end else if (!p_scl && scl_line) begin
      if (last_rise >= 0 && cyc - last_rise > max_per) max_per = cyc - last_rise;
      last_rise = cyc;
      if (bitpos < 8) sh = {sh[6:0], sda_line};
      bitpos++;
    end else if (p_scl && !scl_line) begin
      if (bitpos == 3 && stretch_len > 0 && str_cnt == 0) begin
        s_scl_low = 1'b1; str_cnt = stretch_len;
      end
      if (bitpos == 8) begin
        rx_q.push_back(sh);
        s_sda_low = (byte_idx != nack_at);
      end else if (bitpos == 9) begin
        s_sda_low = 1'b0; bitpos = 0; byte_idx++;
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr10(logic [9:0] a);
    return {5'b11110, a[9:8], 1'b0};
  endfunction
  function automatic logic [7:0] hdr7(logic [6:0] a);
    return {a, 1'b0};
  endfunction

  task automatic write_byte(logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1'b1;
    @(posedge clk); #1 start_req = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(posedge clk); #1 stop_req = 1'b0;
  endtask

  task automatic wait_end(int s0);
    @(negedge clk);
    while (n_stop == s0 || busy) @(negedge clk);
  endtask

  // sends tx_q; slave NACKs byte nk (-1 none)
  task automatic send_frame(int nk);
    int s0;
    rx_q.delete(); nack_at = nk; s0 = n_stop;
    write_byte(tx_q[0]);
    pulse_start();
    for (int k = 1; k < tx_q.size(); k++) begin
      @(negedge clk);
      while (!wr_ready && !nack_flag) @(negedge clk);
      if (nack_flag) break;
      write_byte(tx_q[k]);
    end
    wait_end(s0);
  endtask

  task automatic check_rx(string req, int nexp);
    chk(req, "byte count", rx_q.size(), nexp);
    for (int k = 0; k < nexp && k < rx_q.size(); k++)
      chk(req, "byte value", rx_q[k], tx_q[k]);
  endtask

  initial begin
    int s0;
    void'($urandom(32'h1C2B_0077));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "scl_oe", scl_oe, 0);   chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "busy", busy, 0);       chk("R1", "tx_empty", tx_empty, 1);
    chk("R1", "wr_ready", wr_ready, 1); chk("R1", "start_pend", start_pend, 0);
    chk("R1", "stop_pend", stop_pend, 0); chk("R1", "nack_flag", nack_flag, 0);
    chk("R1", "irq", irq, 0);

    // R3 interrupt gating
    cfg_en = 1'b1; cfg_txie = 1'b1; @(negedge clk);
    chk("R3", "irq en+txie+empty", irq, 1);
    cfg_txie = 1'b0; @(negedge clk);
    chk("R3", "irq txie off", irq, 0);
    cfg_txie = 1'b1;

    // R4 no START with empty register
    s0 = n_start;
    pulse_start();
    repeat (100) @(negedge clk);
    chk("R4", "start with empty reg", n_start - s0, 0);
    chk("R4", "start bit held", start_pend, 1);
    // R4 no START while disabled
    cfg_en = 1'b0;
    tx_q = '{hdr7(7'h52)};
    rx_q.delete(); nack_at = -1;
    write_byte(tx_q[0]);
    @(negedge clk);
    chk("R2", "write clears empty", tx_empty, 0);
    chk("R2", "ready follows empty", wr_ready, 0);
    chk("R3", "irq when full", irq, 0);
    repeat (100) @(negedge clk);
    chk("R4", "start while disabled", n_start - s0, 0);
    s0 = n_stop;
    cfg_en = 1'b1;
    wait_end(s0);
    chk("R4", "one start", n_start, 1);
    chk("R4", "start bit self-cleared", start_pend, 0);
    chk("R2", "empty after load", tx_empty, 1);
    check_rx("R5", 1);
    chk("R10", "bit period", max_per, BITP);

    // R5 7-bit write, several data bytes
    tx_q = '{hdr7(7'h3A), 8'h81, 8'h7E, 8'h00};
    send_frame(-1);
    check_rx("R5", 4);
    chk("R7", "stop seen", n_stop, n_start);
    chk("R6", "no nack", nack_flag, 0);
    chk("R10", "bit period 7b", max_per, BITP);

    // R9 10-bit addressing
    tx_q = '{hdr10(10'h2B5), 8'hB5, 8'hC3};
    send_frame(-1);
    check_rx("R9", 3);
    chk("R9", "first byte literal", rx_q[0], 8'hF4);

    // R6 NACK mid-frame
    tx_q = '{hdr7(7'h11), 8'h22, 8'h33, 8'h44};
    send_frame(1);
    check_rx("R6", 2);
    chk("R6", "nack flag", nack_flag, 1);
    chk("R6", "held byte discarded", tx_empty, 1);
    chk("R6", "stop after nack", n_stop, n_start);

    // R7 STOP request leaves a held byte
    tx_q = '{hdr7(7'h45), 8'h9C};
    rx_q.delete(); nack_at = -1; s0 = n_stop;
    write_byte(tx_q[0]);
    pulse_start();
    @(negedge clk);
    chk("R6", "nack cleared by start", nack_flag, 0);
    write_byte(tx_q[1]);
    pulse_stop();
    wait_end(s0);
    chk("R7", "bytes before stop", rx_q.size(), 1);
    chk("R7", "byte value", rx_q[0], tx_q[0]);
    chk("R7", "held byte kept", tx_empty, 0);
    chk("R7", "stop bit self-cleared", stop_pend, 0);
    rx_q.delete(); s0 = n_stop;
    pulse_start();
    wait_end(s0);
    chk("R7", "held byte sent later", rx_q.size(), 1);
    chk("R7", "held byte value", rx_q[0], tx_q[1]);

    // R8 clock stretching
    stretch_len = 37;
    tx_q = '{hdr7(7'h6D), 8'h5A, 8'hA5};
    send_frame(-1);
    check_rx("R8", 3);
    chk("R8", "stretch lengthens period", int'(max_per > BITP), 1);
    stretch_len = 0;

    // random frames
    for (int i = 0; i < 8; i++) begin
      int nd, nk, len, exp_n;
      logic [9:0] a;
      a = 10'($urandom);
      nd = 1 + int'($urandom % 3);
      tx_q.delete();
      if ($urandom % 2 == 1) begin
        tx_q.push_back(hdr10(a)); tx_q.push_back(a[7:0]);
      end else begin
        tx_q.push_back(hdr7(a[6:0]));
      end
      for (int k = 0; k < nd; k++) tx_q.push_back(8'($urandom));
      len = tx_q.size();
      nk = ($urandom % 3 == 0) ? int'($urandom % len) : -1;
      stretch_len = ($urandom % 3 == 0) ? 23 : 0;
      send_frame(nk);
      exp_n = (nk >= 0) ? nk + 1 : len;
      check_rx((nk >= 0) ? "R6" : "R9", exp_n);
      chk("R6", "random nack flag", nack_flag, int'(nk >= 0));
      chk("R7", "random stop", n_stop, n_start);
      if (stretch_len == 0) chk("R10", "random period", max_per, BITP);
    end
    stretch_len = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule